// File: doc/BRIEF.md
# Bus Turnaround Gap Inserter

This block stands in front of a static-memory transaction sequencer. It decides how many idle clock cycles must separate two back-to-back accesses. It keeps a record of the last transaction it granted: its direction, whether it was synchronous, its bank, and whether it used an address/data multiplexed or D-style access. When a new request arrives, the block compares the pair and picks the gap. Fixed per-pair rules take precedence over a 4-bit programmable turnaround count. The block counts that gap down and then raises ready.

The upstream side holds a request on a valid/ready handshake. The request is accepted on the clock edge where both signals are high. The accepted attributes then become the new history. The programmable count is held in a small register that software writes through a write-enable and a data input.

Top module: `turnaround_gate`

## Requirements
- R1: The turnaround register resets to 15. A cycle with `cfg_we` high loads `cfg_wdata` at that edge.
- R2: The first request after reset sees a gap of 0 cycles.
- R3: An asynchronous write followed by an asynchronous write to the same bank gets a gap of 0, provided that neither access is multiplexed.
- R4: A gap of 1 follows a non-multiplexed asynchronous read when the next access is a write of any kind, a read to a different bank, or an asynchronous read.
- R5: After a synchronous write, the gap is 2 before a synchronous write to the same bank and 2 before any asynchronous access.
- R6: After a synchronous write, the gap is 3 before a synchronous write to a different bank and 3 before any synchronous read.
- R7: The programmed count is the gap after an asynchronous write that R3 does not cover. It is also the gap after a multiplexed asynchronous read.
- R8: Every other pair gets a gap of 0. This covers anything after a synchronous read, and a non-multiplexed asynchronous read followed by a synchronous read to the same bank.
- R9: With `req_valid` held high, `req_ready` rises exactly gap cycles after the first edge that sees the request. It stays high until the acceptance edge and is low on the cycle after acceptance.
- R10: A write to the turnaround register during a running countdown leaves that countdown unchanged. The new value applies to later requests.
- R11: While no request is pending, `req_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the turnaround register |
| cfg_wdata | input | 4 | New programmable turnaround count |
| req_valid | input | 1 | Request pending; held until accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sync | input | 1 | 1 = synchronous access |
| req_bank | input | 2 | Target bank number |
| req_mux | input | 1 | 1 = multiplexed or D-style access |
| req_ready | output | 1 | Gap elapsed; request may start |

## Verification
Some checks run on every cycle inside the timer. Ready is never high while the counter is non-zero. The counter drops by exactly one per cycle, whatever happens on the configuration port. Ready falls after acceptance, and it stays low while the block is idle with no request. Which gap each pair of transactions receives can only be shown by the bench scenarios. So can the reset value of the register, the zero gap after reset, and the rule that a mid-countdown register write takes effect only on the next request.

// File: rtl/ta_pkg.sv
package ta_pkg;
  localparam int BANK_W   = 2;
  localparam int TURN_W   = 4;
  localparam int TURN_RST = 15;

  typedef struct packed {
    logic              write;
    logic              sync;
    logic [BANK_W-1:0] bank;
    logic              mux;
  } xfer_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_GRANT} tstate_t;
endpackage

// File: rtl/ta_cfg_reg.sv
module ta_cfg_reg
  import ta_pkg::*;
#(
  parameter int W   = TURN_W,
  parameter int RST = TURN_RST
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= W'(RST);
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/ta_history.sv
module ta_history
  import ta_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  fire,
  input  xfer_t nxt,
  output logic  vld,
  output xfer_t prev
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= 1'b0;
      prev <= '0;
    end else if (fire) begin
      vld  <= 1'b1;
      prev <= nxt;
    end
  end
endmodule

// File: rtl/ta_rule.sv
module ta_rule
  import ta_pkg::*;
#(
  parameter int W = TURN_W
) (
  input  logic         hist_vld,
  input  xfer_t        prev,
  input  xfer_t        nxt,
  input  logic [W-1:0] prog,
  output logic [W-1:0] gap
);
  logic same_bank;
  assign same_bank = (prev.bank == nxt.bank);

  always_comb begin
    gap = '0;
    if (!hist_vld) begin
      gap = '0;
    end else if (prev.write && prev.sync) begin
      if (!nxt.sync)                      gap = W'(2);
      else if (nxt.write && same_bank)    gap = W'(2);
      else                                gap = W'(3);
    end else if (prev.write) begin
      if (nxt.write && !nxt.sync && same_bank && !prev.mux && !nxt.mux)
        gap = '0;
      else
        gap = prog;
    end else if (!prev.sync) begin
      if (prev.mux)                                   gap = prog;
      else if (nxt.write || !same_bank || !nxt.sync)  gap = W'(1);
      else                                            gap = '0;
    end
  end
endmodule

// File: rtl/ta_timer.sv
module ta_timer
  import ta_pkg::*;
#(
  parameter int W = TURN_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid,
  input  logic [W-1:0] gap,
  output logic         ready,
  output logic         fire
);
  tstate_t      st;
  logic [W-1:0] cnt;

  assign ready = (st == ST_GRANT);
  assign fire  = ready && valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        ST_IDLE: if (valid) begin
          cnt <= gap;
          st  <= (gap == '0) ? ST_GRANT : ST_WAIT;
        end
        ST_WAIT: begin
          cnt <= cnt - W'(1);
          if (cnt == W'(1)) st <= ST_GRANT;
        end
        ST_GRANT: if (valid) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_ready_only_at_zero_R9: assert property (@(posedge clk) disable iff (rst)
    ready |-> cnt == '0);
  assert_count_down_R10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT) |=> cnt == $past(cnt) - W'(1));
  assert_drop_after_fire_R9: assert property (@(posedge clk) disable iff (rst)
    fire |=> !ready);
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !valid) |=> !ready);
endmodule

// File: rtl/turnaround_gate.sv
module turnaround_gate
  import ta_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [TURN_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_sync,
  input  logic [BANK_W-1:0] req_bank,
  input  logic              req_mux,
  output logic              req_ready
);
  xfer_t             nxt, prev;
  logic              hist_vld, fire;
  logic [TURN_W-1:0] prog, gap;

  assign nxt = '{write: req_write, sync: req_sync, bank: req_bank, mux: req_mux};

  ta_cfg_reg #(.W(TURN_W), .RST(TURN_RST)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .q(prog));

  ta_history u_hist (
    .clk(clk), .rst(rst), .fire(fire), .nxt(nxt), .vld(hist_vld), .prev(prev));

  ta_rule #(.W(TURN_W)) u_rule (
    .hist_vld(hist_vld), .prev(prev), .nxt(nxt), .prog(prog), .gap(gap));

  ta_timer #(.W(TURN_W)) u_tmr (
    .clk(clk), .rst(rst), .valid(req_valid), .gap(gap),
    .ready(req_ready), .fire(fire));
endmodule

// File: tb/sim_turnaround_gate.sv
module sim_turnaround_gate;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_wdata = '0;
  logic       req_valid = 1'b0, req_write = 1'b0, req_sync = 1'b0, req_mux = 1'b0;
  logic [1:0] req_bank = '0;
  logic       req_ready;

  int total = 0, bad = 0, waitc = 0;
  int exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #10 clk = ~clk;

  turnaround_gate u0 (.*);

  // monitor: a request driven at posedge+2 is first seen one edge later,
  // so the number of low-ready negedges equals gap+1
  always @(negedge clk) begin
    if (!rst && req_valid) begin
      if (req_ready) begin
        total++;
        if (exp_q.size() == 0) begin
          bad++; $display("FAIL %s grant with empty queue: got %0d expected none", "R9", waitc - 1);
        end else begin
          automatic int e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          if (waitc != e + 1) begin
            bad++; $display("FAIL %s gap got %0d expected %0d", t, waitc - 1, e);
          end
        end
        waitc = 0;
      end else waitc++;
    end
  end

  task automatic cfg_write(input logic [3:0] v);
    @(posedge clk); #2 cfg_we = 1'b1; cfg_wdata = v;
    @(posedge clk); #2 cfg_we = 1'b0;
  endtask

  task automatic do_req(input logic w, input logic s, input logic [1:0] b,
                        input logic m, input int e, input string t,
                        input bit mid = 0, input logic [3:0] mv = '0);
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #2;
    req_valid = 1'b1; req_write = w; req_sync = s; req_bank = b; req_mux = m;
    if (mid) cfg_write(mv);
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #2 req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    total++;
    if (req_ready !== 1'b0) begin bad++; $display("FAIL R11 reset ready got %b expected 0", req_ready); end

    do_req(0, 0, 2'd0, 0, 0,  "R2");
    do_req(0, 0, 2'd0, 0, 1,  "R4");
    do_req(0, 0, 2'd1, 0, 1,  "R4");
    do_req(1, 0, 2'd1, 0, 1,  "R4");
    do_req(1, 0, 2'd1, 0, 0,  "R3");
    do_req(1, 0, 2'd1, 1, 15, "R1");
    cfg_write(4'd5);
    do_req(1, 0, 2'd0, 0, 5,  "R7");
    do_req(1, 1, 2'd0, 0, 5,  "R7");
    do_req(1, 1, 2'd0, 0, 2,  "R5");
    do_req(1, 1, 2'd2, 0, 3,  "R6");
    do_req(0, 1, 2'd1, 0, 3,  "R6");
    do_req(1, 1, 2'd1, 0, 0,  "R8");
    do_req(0, 0, 2'd1, 0, 2,  "R5");
    do_req(0, 0, 2'd1, 1, 1,  "R4");
    do_req(0, 0, 2'd1, 0, 5,  "R7");
    do_req(0, 1, 2'd1, 0, 0,  "R8");
    do_req(1, 0, 2'd0, 0, 0,  "R8");
    do_req(1, 0, 2'd1, 0, 5,  "R10", 1, 4'd9);
    do_req(1, 0, 2'd2, 0, 9,  "R10");

    repeat (6) begin
      @(negedge clk);
      total++;
      if (req_ready !== 1'b0) begin bad++; $display("FAIL R11 idle ready got %b expected 0", req_ready); end
    end
    total++;
    if (exp_q.size() != 0) begin bad++; $display("FAIL R9 pending grants got %0d expected 0", exp_q.size()); end
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin total++; bad++; $display("FAIL watchdog got hang expected finish"); end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule